// File: doc/BRIEF.md
# AES Round-Key Expansion Engine

This block turns an AES cipher key of 128, 192 or 256 bits into the complete sequence of 128-bit round keys for encryption. A one-cycle `start` pulse latches the key bus and the length selector. The engine then produces one 32-bit schedule word per cycle. It packs these words into round keys and hands each key out on a valid/ready stream, beginning with round key 0. The number of cipher rounds for the selected length is shown on `rounds` from the cycle after `start`.

The key bus is 256 bits wide and left-justified. Schedule word 0 is taken from bits 255:224, and a shorter key uses only its leading 16 or 24 bytes. One shared word datapath serves every length. Only the window depth it reads back, the places where a substitution step is inserted, and the rule for advancing the round constant change with the mode. The S-box is computed in logic and is instantiated four times, so a whole word is substituted in one cycle.

The output stream follows the usual rules. Once `rk_valid` rises, it stays high and `rk_data` stays unchanged until a cycle in which `rk_ready` is high. While a key is waiting, the producer stops, so back-pressure never loses or reorders a key. After the consumer accepts the last key, `done` pulses for one cycle and `busy` falls.

Top module: `aes_key_expander`

## Requirements
- R1: `rounds` shows 10 when `key_len` was 2'b00 at the accepted start, 12 for 2'b01, and 14 for any other code (2'b10 or 2'b11). After reset it shows 10.
- R2: Exactly `rounds`+1 round keys are delivered, in order. Round key 0 equals `key_in[255:128]` as sampled at start. Key bits below the selected length have no effect on any round key.
- R3: In 128-bit mode, every round key matches the standard expansion. The round constant starts at 0x01 and is doubled in GF(2^8) with reduction by 0x11B, so it reaches 0x1B and 0x36 in the last two steps.
- R4: In 192-bit mode, all 13 round keys match the standard expansion (52 words). The final key is formed from words 48..51, and the round constant is advanced by a plain left shift.
- R5: In 256-bit mode, all 15 round keys match the standard expansion. Each word at position 4 within an 8-word group takes an S-box pass without rotation and without a constant.
- R6: Within `rk_data`, schedule word 4k of round key k sits in bits 127:96 and word 4k+3 in bits 31:0. Each word is big-endian: its first key byte is in the top byte.
- R7: While `rk_valid` is high and `rk_ready` is low, `rk_valid` stays high and `rk_data` stays unchanged on the next cycle.
- R8: `done` is high for exactly one cycle, the cycle after the last round key is accepted. In that cycle `busy` is low.
- R9: A `start` pulse while `busy` is high has no effect on `rounds` or on any delivered round key.
- R10: After reset, `busy`, `rk_valid` and `done` are low.
- R11: `rk_valid` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to latch `key_in` and `key_len`; ignored while busy |
| key_len | input | 2 | Length code: 00 = 128, 01 = 192, other = 256 bits |
| key_in | input | 256 | Left-justified cipher key |
| busy | output | 1 | Expansion in progress |
| rounds | output | 4 | Round count for the latched length |
| rk_valid | output | 1 | Round key available |
| rk_ready | input | 1 | Consumer accepts the round key this cycle |
| rk_data | output | 128 | Round key, schedule word 4k in the top 32 bits |
| done | output | 1 | One-cycle pulse after the last key is accepted |

## Verification
The main function is exercised with three families of key. The standard example keys for each length pin the absolute values, including last round keys that depend on correct constant reduction in 128-bit mode. Keys with the unused low bytes filled with junk show that only the leading bytes are read. Both 2'b10 and 2'b11 for 256 bits confirm that any code other than 00 and 01 selects the longest mode. Each run uses a different back-pressure level, from none to heavy, to separate correct stall handling from mere data correctness. The runs with a mid-run start pulse show whether a busy engine can be disturbed.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

  typedef logic [31:0] word_t;

  typedef enum logic [1:0] {
    KL_128 = 2'b00,
    KL_192 = 2'b01,
    KL_256 = 2'b10
  } klen_e;

  // GF(2^8) product modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  // forward substitution: multiplicative inverse (a^254) then affine map
  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] sq;
    r  = 8'h01;
    sq = a;
    for (int k = 1; k < 8; k++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
             ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  function automatic klen_e decode_len(input logic [1:0] code);
    case (code)
      2'b00:   return KL_128;
      2'b01:   return KL_192;
      default: return KL_256;
    endcase
  endfunction

endpackage

// File: rtl/aes_sub_word.sv
module aes_sub_word
  import aes_kx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] din,
  output logic [8*LANES-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[8*g +: 8] = sub_byte(din[8*g +: 8]);
  end
endmodule

// File: rtl/aes_rcon_gen.sv
module aes_rcon_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       advance,
  input  logic       reduce,
  output logic [7:0] rcon
);
  logic [7:0] shifted;

  always_comb begin
    shifted = {rcon[6:0], 1'b0};
    if (reduce && rcon[7]) shifted = shifted ^ 8'h1B;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rcon <= 8'h01;
    else if (init)    rcon <= 8'h01;
    else if (advance) rcon <= shifted;
  end
endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander
  import aes_kx_pkg::*;
#(
  parameter int KEY_W = 256,
  parameter int RK_W  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        key_len,
  input  logic [KEY_W-1:0]  key_in,
  output logic              busy,
  output logic [3:0]        rounds,
  output logic              rk_valid,
  input  logic              rk_ready,
  output logic [RK_W-1:0]   rk_data,
  output logic              done
);
  localparam int WIN        = KEY_W / 32;
  localparam int RK_WORDS   = RK_W / 32;
  localparam int WIN_AW     = $clog2(WIN);
  localparam int AC_W       = $clog2(RK_WORDS);
  localparam int ROUNDS_MAX = WIN + 6;
  localparam int TOTAL_MAX  = RK_WORDS * (ROUNDS_MAX + 1);
  localparam int CNT_W      = $clog2(TOTAL_MAX + 1);

  klen_e            mode_q;
  logic             running;
  logic [CNT_W-1:0] wcnt;
  logic [CNT_W-1:0] phase;
  word_t            win  [WIN];
  word_t            keyw [WIN];
  word_t            acc  [RK_WORDS];
  logic [AC_W-1:0]  acc_cnt;
  logic             out_valid;
  logic             done_q;

  logic [CNT_W-1:0] nk_w;
  logic [CNT_W-1:0] total_w;
  logic [3:0]       rounds_w;
  word_t            prev_w;
  word_t            back_w;
  word_t            sub_in;
  word_t            sub_out;
  word_t            temp_w;
  word_t            new_word;
  logic [7:0]       rcon;
  logic             accept;
  logic             produce;
  logic             rcon_step;
  logic             handshake;

  // per-mode constants
  always_comb begin
    case (mode_q)
      KL_128: begin nk_w = CNT_W'(4); total_w = CNT_W'(44); rounds_w = 4'd10; end
      KL_192: begin nk_w = CNT_W'(6); total_w = CNT_W'(52); rounds_w = 4'd12; end
      default: begin nk_w = CNT_W'(8); total_w = CNT_W'(60); rounds_w = 4'd14; end
    endcase
  end

  assign accept    = start && !running;
  assign produce   = running && !out_valid && (wcnt < total_w);
  assign handshake = out_valid && rk_ready;
  assign rcon_step = produce && (wcnt >= nk_w) && (phase == '0);

  // window: win[WIN-1] is the newest word, the word nk back depends on mode
  assign prev_w = win[WIN-1];
  always_comb begin
    case (mode_q)
      KL_128:  back_w = win[WIN-4];
      KL_192:  back_w = win[WIN-6];
      default: back_w = win[0];
    endcase
  end

  assign sub_in = (phase == '0) ? {prev_w[23:0], prev_w[31:24]} : prev_w;

  aes_sub_word #(.LANES(4)) u_sub (
    .din  (sub_in),
    .dout (sub_out)
  );

  aes_rcon_gen u_rcon (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (accept),
    .advance (rcon_step),
    .reduce  (mode_q == KL_128),
    .rcon    (rcon)
  );

  always_comb begin
    if (phase == '0)
      temp_w = sub_out ^ {rcon, 24'h000000};
    else if (mode_q == KL_256 && phase == CNT_W'(4))
      temp_w = sub_out;
    else
      temp_w = prev_w;
  end

  assign new_word = (wcnt < nk_w) ? keyw[wcnt[WIN_AW-1:0]] : (back_w ^ temp_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      mode_q    <= KL_128;
      wcnt      <= '0;
      phase     <= '0;
      acc_cnt   <= '0;
      out_valid <= 1'b0;
      done_q    <= 1'b0;
      for (int j = 0; j < WIN; j++) begin
        win[j]  <= '0;
        keyw[j] <= '0;
      end
      for (int j = 0; j < RK_WORDS; j++) acc[j] <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        running   <= 1'b1;
        mode_q    <= decode_len(key_len);
        wcnt      <= '0;
        phase     <= '0;
        acc_cnt   <= '0;
        out_valid <= 1'b0;
        for (int j = 0; j < WIN; j++) keyw[j] <= key_in[KEY_W-1-32*j -: 32];
      end
      if (produce) begin
        for (int j = 0; j < WIN-1; j++) win[j] <= win[j+1];
        win[WIN-1]   <= new_word;
        acc[acc_cnt] <= new_word;
        if (acc_cnt == AC_W'(RK_WORDS-1)) begin
          acc_cnt   <= '0;
          out_valid <= 1'b1;
        end else begin
          acc_cnt <= acc_cnt + 1'b1;
        end
        wcnt  <= wcnt + 1'b1;
        phase <= (phase == nk_w - 1'b1) ? '0 : phase + 1'b1;
      end
      if (handshake) begin
        out_valid <= 1'b0;
        if (wcnt == total_w) begin
          running <= 1'b0;
          done_q  <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < RK_WORDS; g++) begin : g_pack
    assign rk_data[RK_W-1-32*g -: 32] = acc[g];
  end

  assign busy     = running;
  assign rounds   = rounds_w;
  assign rk_valid = out_valid;
  assign done     = done_q;

endmodule

// File: rtl/aes_key_expander_chk.sv
module aes_key_expander_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic [3:0]   rounds,
  input logic         rk_valid,
  input logic         rk_ready,
  input logic [127:0] rk_data,
  input logic         done
);
  p_rounds_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rounds == 4'd10) || (rounds == 4'd12) || (rounds == 4'd14));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid && !rk_ready |=> rk_valid && $stable(rk_data));

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(rk_valid && rk_ready));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy && $stable(rounds));

  p_valid_needs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid |-> busy);

  p_start_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && !rk_valid);
endmodule

bind aes_key_expander aes_key_expander_chk u_chk (.*);

// File: tb/aes_key_expander_test.sv
`timescale 1ns/1ps
module aes_key_expander_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   key_len = 2'b00;
  logic [255:0] key_in = '0;
  logic         busy;
  logic [3:0]   rounds;
  logic         rk_valid;
  logic         rk_ready = 1'b0;
  logic [127:0] rk_data;
  logic         done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0]   sb [256];
  logic [31:0]  ref_w [60];
  logic [127:0] cap [15];

  always #10 clk = ~clk;

  aes_key_expander uut (
    .clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len), .key_in(key_in),
    .busy(busy), .rounds(rounds), .rk_valid(rk_valid), .rk_ready(rk_ready),
    .rk_data(rk_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // S-box built by walking generator 3 and its inverse
  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  task automatic build_ref(input int nk, input logic [255:0] key);
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < nk; i++) ref_w[i] = key[255-32*i -: 32];
    for (int i = nk; i < 4*(nk+7); i++) begin
      t = ref_w[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1B : 8'h00);
      end else if (nk == 8 && i % 8 == 4) begin
        t = subw(t);
      end
      ref_w[i] = ref_w[i-nk] ^ t;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy after reset", 128'(busy), 128'd0);
    chk(rk_valid == 1'b0, "R10/R11 valid after reset", 128'(rk_valid), 128'd0);
    chk(done == 1'b0, "R10 done after reset", 128'(done), 128'd0);
    chk(rounds == 4'd10, "R1 rounds after reset", 128'(rounds), 128'd10);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one expansion with back-pressure level 'stall' (percent), optional mid-run start
  task automatic t_run(input logic [1:0] code, input logic [255:0] key, input int nk,
                       input int stall, input bit poke, input string req);
    int nkeys, got, cyc;
    bit held;
    logic [127:0] prevd, expk;
    build_ref(nk, key);
    nkeys = nk + 7;
    key_len = code; key_in = key; start = 1'b1;
    @(negedge clk);
    start = 1'b0; key_in = ~key;
    chk(busy == 1'b1, "R2 busy after start", 128'(busy), 128'd1);
    chk(rounds == 4'(nk + 6), "R1 rounds for length", 128'(rounds), 128'(nk + 6));
    got = 0; cyc = 0; held = 1'b0; prevd = '0;
    while (got < nkeys && cyc < 4000) begin
      if (held) chk(rk_valid && rk_data == prevd, "R7 held key stable", rk_data, prevd);
      rk_ready = ($urandom % 100) >= stall;
      if (poke && cyc == 9) begin
        start = 1'b1; key_len = (code == 2'b00) ? 2'b01 : 2'b00;
      end else begin
        start = 1'b0;
      end
      if (rk_valid && rk_ready) begin
        expk = {ref_w[4*got], ref_w[4*got+1], ref_w[4*got+2], ref_w[4*got+3]};
        chk(rk_data == expk, req, rk_data, expk);
        if (got == 0) begin
          chk(rk_data == key[255:128], "R2 key 0 is the key", rk_data, key[255:128]);
          chk(rk_data[127:120] == key[255:248], "R6 byte order", 128'(rk_data[127:120]), 128'(key[255:248]));
        end
        cap[got] = rk_data;
        got++;
      end
      held  = rk_valid && !rk_ready;
      prevd = rk_data;
      @(negedge clk);
      cyc++;
    end
    rk_ready = 1'b0; start = 1'b0;
    chk(got == nkeys, "R2 key count", 128'(got), 128'(nkeys));
    chk(done == 1'b1 && busy == 1'b0, "R8 done pulse", {done, busy}, 128'b10);
    chk(rk_valid == 1'b0, "R11 no valid after end", 128'(rk_valid), 128'd0);
    chk(rounds == 4'(nk + 6), "R9 rounds unchanged", 128'(rounds), 128'(nk + 6));
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", 128'(done), 128'd0);
  endtask

  task automatic t_aes128();
    logic [255:0] k;
    k = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
    t_run(2'b00, k, 4, 0, 1'b0, "R3 128-bit round key");
    chk(cap[1] == 128'ha0fafe1788542cb123a339392a6c7605, "R3 published key 1", cap[1], 128'ha0fafe1788542cb123a339392a6c7605);
    chk(cap[10] == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R3 published key 10", cap[10], 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    k[127:0] = 128'hfeedc0de_0badf00d_12345678_9abcdef0;
    t_run(2'b00, k, 4, 60, 1'b1, "R9 128-bit with start while busy");
    chk(cap[10] == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R2 unused bytes ignored", cap[10], 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
  endtask

  task automatic t_aes192();
    logic [255:0] k;
    k = {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'hdeadbeef_cafef00d};
    t_run(2'b01, k, 6, 30, 1'b1, "R4 192-bit round key");
    chk(cap[12] == 128'he98ba06f448c773c8ecc720401002202, "R4 published final key", cap[12], 128'he98ba06f448c773c8ecc720401002202);
  endtask

  task automatic t_aes256();
    logic [255:0] k;
    k = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
    t_run(2'b10, k, 8, 50, 1'b0, "R5 256-bit round key");
    chk(cap[14] == 128'hfe4890d1e6188d0b046df344706c631e, "R5 published final key", cap[14], 128'hfe4890d1e6188d0b046df344706c631e);
    t_run(2'b11, ~k, 8, 0, 1'b1, "R1 code 11 selects 256-bit");
  endtask

  initial begin
    build_sbox();
    chk(sb[8'h53] == 8'hed && sb[8'h00] == 8'h63, "R3 bench S-box", {sb[8'h53], sb[8'h00]}, 128'hed63);
    t_reset();
    t_aes128();
    t_aes192();
    t_aes256();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule